// File: doc/BRIEF.md
# UART transmitter register front end

This block connects an 8-bit register bus to a separate serial transmitter stage. Software enables the transmitter, sets a 16-bit baud divisor and writes characters one at a time. Each accepted character is held in a one-entry buffer and handed to the transmitter stage on a payload/valid/ready handshake. The block does not generate serial bits or baud timing. It only controls, queues and configures. While the block is disabled, it holds the transmitter stage in reset.

The register bus is single-cycle. An access is an address together with a read strobe or a write strobe. Read data is registered. It appears on `csr_rdata` in the cycle after the read strobe and is zero in every other cycle. With the default `DATA_W` of 8, the byte offsets are:

| Offset | Register |
|---|---|
| 0 | control: bit 0 is enable |
| 1 | status: bit 0 is buffer ready |
| 2 | divisor bits 7:0 |
| 3 | divisor bits 15:8 |
| 4 | transmit data (write-only) |

All other offsets are unmapped. The reset input is active-low and asynchronous. The system must release it synchronously to `clk`.

Top module: `uart_tx_csr`

## Requirements
- R1: After reset, enable is 0, `phy_rst` is 1, `phy_valid` is 0, `phy_divisor` equals `DIV_INIT`, and status bit 0 reads 1.
- R2: A write to offset 0 loads enable from `csr_wdata[0]`. From the next cycle, `phy_rst` equals the inverse of enable. A read of offset 0 returns enable in bit 0 and zeros in bits 7:1.
- R3: A read of offset 1 returns 1 in bit 0 when the buffer is empty and 0 when it holds a character. Bits 7:1 read 0.
- R4: While enable is 0, a write to offset 2 loads divisor bits 7:0 and a write to offset 3 loads bits 15:8. The new value drives `phy_divisor` from the next cycle and reads back at the same offsets.
- R5: While enable is 1, writes to offsets 2 and 3 leave the divisor unchanged.
- R6: A write to offset 4 while enable is 1 and the buffer is empty makes `phy_valid` 1 in the next cycle. `phy_payload` then equals `csr_wdata[SYM_W-1:0]`.
- R7: A write to offset 4 while the buffer is full is dropped. `phy_payload` stays unchanged.
- R8: A write to offset 4 while enable is 0 is dropped. `phy_valid` stays 0, including after a later enable.
- R9: A clock edge with `phy_valid` and `phy_ready` both 1 hands the character over. `phy_valid` is 0 in the next cycle. While `phy_ready` is 0, `phy_valid` and `phy_payload` hold. Characters reach the transmitter stage in write order.
- R10: Writing 0 to enable discards a held character. `phy_valid` is 0 in the same cycle that `phy_rst` becomes 1.
- R11: `csr_rdata` carries the addressed value in the cycle after `csr_rd` and is 0 otherwise. Reads of offset 4 and of unmapped offsets return 0, and no read changes any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| csr_addr | input | ADDR_W | Register offset |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | DATA_W | Write data |
| csr_rdata | output | DATA_W | Registered read data, one cycle after the strobe |
| phy_rst | output | 1 | Transmitter stage reset, high while disabled |
| phy_divisor | output | 16 | Baud divisor for the transmitter stage |
| phy_payload | output | SYM_W | Character offered to the transmitter stage |
| phy_valid | output | 1 | Character offered |
| phy_ready | input | 1 | Transmitter stage can take a character |

## Verification
The bench writes a character while the buffer is full and checks that the held payload survives. A design that overwrote it would change `phy_payload` mid-offer. The bench disables the block while a character is held and expects `phy_valid` to fall in the same cycle that `phy_rst` rises. A design that flushed one cycle late would offer a stale symbol to a stage that is in reset. It also writes the divisor while enabled, writes data while disabled and then re-enables. A design with a missing lock or gate would change the baud rate under a running transmitter or emit a ghost character. A back-to-back stream with `phy_ready` held high tests handshake ordering and the full-buffer gate in alternating cycles.

// File: rtl/uart_tx_csr_pkg.sv
package uart_tx_csr_pkg;
  localparam int DIV_W    = 16;
  localparam int OFS_CTRL = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_DIV  = 2;
endpackage

// File: rtl/uart_tx_cfg.sv
module uart_tx_cfg
  import uart_tx_csr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_INIT = 868,
  localparam int NLANE   = DIV_W / DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [NLANE-1:0]  wr_lane,
  input  logic [DATA_W-1:0] wdata,
  output logic              en_q,
  output logic              flush,
  output logic [DIV_W-1:0]  div_q
);
  logic             en_d;
  logic [DIV_W-1:0] div_d;
  logic             div_ce;

  always_comb begin
    en_d  = wr_ctrl ? wdata[0] : en_q;
    flush = wr_ctrl && !wdata[0];
  end

  always_comb begin
    div_d  = div_q;
    div_ce = 1'b0;
    for (int i = 0; i < NLANE; i++) begin
      if (wr_lane[i] && !en_q) begin
        div_d[i*DATA_W +: DATA_W] = wdata;
        div_ce = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(DIV_INIT);
    end else if (div_ce) begin
      div_q <= div_d;
    end
  end
endmodule

// File: rtl/uart_tx_symbuf.sv
module uart_tx_symbuf #(
  parameter int SYM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             flush,
  input  logic             push,
  input  logic [SYM_W-1:0] push_data,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [SYM_W-1:0] out_data,
  output logic             room
);
  logic vld_d;
  logic take;

  always_comb begin
    take  = push && en && !out_valid;
    vld_d = out_valid;
    if (out_valid && out_ready) vld_d = 1'b0;
    if (take)                   vld_d = 1'b1;
    if (flush || !en)           vld_d = 1'b0;
    room  = !out_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
    end else if (take) begin
      out_data <= push_data;
    end
  end
endmodule

// File: rtl/uart_tx_readback.sv
module uart_tx_readback
  import uart_tx_csr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int NLANE = DIV_W / DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  input  logic              room,
  input  logic [DIV_W-1:0]  div,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    word = '0;
    if (addr == ADDR_W'(OFS_CTRL)) word[0] = en;
    if (addr == ADDR_W'(OFS_STAT)) word[0] = room;
    for (int i = 0; i < NLANE; i++) begin
      if (addr == ADDR_W'(OFS_DIV + i)) word = div[i*DATA_W +: DATA_W];
    end
    rdata_d = rd ? word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else begin
      rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/uart_tx_csr.sv
module uart_tx_csr
  import uart_tx_csr_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int SYM_W    = 8,
  parameter int DIV_INIT = 868
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic              csr_rd,
  input  logic              csr_wr,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  output logic              phy_rst,
  output logic [DIV_W-1:0]  phy_divisor,
  output logic [SYM_W-1:0]  phy_payload,
  output logic              phy_valid,
  input  logic              phy_ready
);
  localparam int NLANE    = DIV_W / DATA_W;
  localparam int OFS_DATA = OFS_DIV + NLANE;

  logic             wr_ctrl;
  logic             wr_data;
  logic [NLANE-1:0] wr_lane;
  logic             en;
  logic             flush;
  logic             room;

  assign wr_ctrl = csr_wr && (csr_addr == ADDR_W'(OFS_CTRL));
  assign wr_data = csr_wr && (csr_addr == ADDR_W'(OFS_DATA));

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign wr_lane[g] = csr_wr && (csr_addr == ADDR_W'(OFS_DIV + g));
  end

  uart_tx_cfg #(.DATA_W(DATA_W), .DIV_INIT(DIV_INIT)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_lane(wr_lane),
    .wdata(csr_wdata), .en_q(en), .flush(flush), .div_q(phy_divisor)
  );

  uart_tx_symbuf #(.SYM_W(SYM_W)) buf_i (
    .clk(clk), .rst_n(rst_n), .en(en), .flush(flush), .push(wr_data),
    .push_data(csr_wdata[SYM_W-1:0]), .out_ready(phy_ready),
    .out_valid(phy_valid), .out_data(phy_payload), .room(room)
  );

  uart_tx_readback #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) rb_i (
    .clk(clk), .rst_n(rst_n), .rd(csr_rd), .addr(csr_addr), .en(en),
    .room(room), .div(phy_divisor), .rdata(csr_rdata)
  );

  assign phy_rst = !en;
endmodule

// File: rtl/uart_tx_csr_chk.sv
module uart_tx_csr_chk
  import uart_tx_csr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int SYM_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] csr_addr,
  input logic              csr_rd,
  input logic              csr_wr,
  input logic [DATA_W-1:0] csr_wdata,
  input logic [DATA_W-1:0] csr_rdata,
  input logic              phy_rst,
  input logic [DIV_W-1:0]  phy_divisor,
  input logic [SYM_W-1:0]  phy_payload,
  input logic              phy_valid,
  input logic              phy_ready
);
  localparam int OFS_DATA = OFS_DIV + DIV_W / DATA_W;

  // R2
  enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && csr_addr == ADDR_W'(OFS_CTRL)) |=> (phy_rst == !$past(csr_wdata[0])));

  // R5
  divisor_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_rst |=> $stable(phy_divisor));

  // R6
  data_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && csr_addr == ADDR_W'(OFS_DATA) && !phy_rst && !phy_valid)
    |=> (phy_valid && phy_payload == $past(csr_wdata[SYM_W-1:0])));

  // R7
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_valid && !phy_ready && !(csr_wr && csr_addr == ADDR_W'(OFS_CTRL)))
    |=> (phy_valid && $stable(phy_payload)));

  // R8
  no_offer_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phy_rst |=> !phy_valid);

  // R9
  handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_valid && phy_ready) |=> !phy_valid);

  // R10
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phy_rst |-> !phy_valid);

  // R11
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_rd |=> (csr_rdata == '0));
endmodule

bind uart_tx_csr uart_tx_csr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYM_W(SYM_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_rd(csr_rd), .csr_wr(csr_wr),
  .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .phy_rst(phy_rst),
  .phy_divisor(phy_divisor), .phy_payload(phy_payload), .phy_valid(phy_valid),
  .phy_ready(phy_ready)
);

// File: tb/uart_tx_csr_tb_top.sv
`timescale 1ns/100ps
module uart_tx_csr_tb_top;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 8;
  localparam int SYM_W    = 8;
  localparam int DIV_INIT = 868;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] csr_addr = '0;
  logic              csr_rd = 1'b0;
  logic              csr_wr = 1'b0;
  logic [DATA_W-1:0] csr_wdata = '0;
  logic [DATA_W-1:0] csr_rdata;
  logic              phy_rst;
  logic [15:0]       phy_divisor;
  logic [SYM_W-1:0]  phy_payload;
  logic              phy_valid;
  logic              phy_ready = 1'b0;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = !clk;

  uart_tx_csr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYM_W(SYM_W), .DIV_INIT(DIV_INIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_rd(csr_rd), .csr_wr(csr_wr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .phy_rst(phy_rst),
    .phy_divisor(phy_divisor), .phy_payload(phy_payload), .phy_valid(phy_valid),
    .phy_ready(phy_ready)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit       m_en;
  int       m_div;
  bit       m_vld;
  int       m_pld;
  int       m_rd;
  int       exp_q[$];
  int       got_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_div = DIV_INIT; m_vld = 0; m_pld = 0; m_rd = 0;
    end else begin
      bit n_en;
      bit n_vld;
      int a;
      a = int'(csr_addr);
      m_rd = 0;
      if (csr_rd) begin
        case (a)
          0: m_rd = m_en;
          1: m_rd = m_vld ? 0 : 1;
          2: m_rd = m_div & 255;
          3: m_rd = (m_div >> 8) & 255;
          default: m_rd = 0;
        endcase
      end
      n_en  = m_en;
      n_vld = m_vld;
      if (m_vld && phy_ready) begin
        exp_q.push_back(m_pld);
        n_vld = 0;
      end
      if (csr_wr && a == 4 && m_en && !m_vld) begin
        n_vld = 1;
        m_pld = int'(csr_wdata);
      end
      if (csr_wr && a == 0) n_en = csr_wdata[0];
      if (!m_en || (csr_wr && a == 0 && !csr_wdata[0])) n_vld = 0;
      if (csr_wr && !m_en && a == 2) m_div = (m_div & 16'hff00) | int'(csr_wdata);
      if (csr_wr && !m_en && a == 3) m_div = (m_div & 16'h00ff) | (int'(csr_wdata) << 8);
      m_en  = n_en;
      m_vld = n_vld;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 phy_rst", int'(phy_rst), m_en ? 0 : 1);
      check("R4 phy_divisor", int'(phy_divisor), m_div);
      check("R6 phy_valid", int'(phy_valid), int'(m_vld));
      if (m_vld) check("R7 phy_payload", int'(phy_payload), m_pld);
      check("R11 csr_rdata", int'(csr_rdata), m_rd);
      if (phy_valid && phy_ready) got_q.push_back(int'(phy_payload));
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic wr(int a, int d);
    @(posedge clk); #1;
    csr_addr = ADDR_W'(a); csr_wdata = DATA_W'(d); csr_wr = 1'b1;
    @(posedge clk); #1;
    csr_wr = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(posedge clk); #1;
    csr_addr = ADDR_W'(a); csr_rd = 1'b1;
    @(posedge clk); #1;
    csr_rd = 1'b0;
    @(negedge clk);
    v = int'(csr_rdata);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int v;
    #1;
    check("R1 phy_rst in reset", int'(phy_rst), 1);
    check("R1 phy_valid in reset", int'(phy_valid), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 divisor after reset", int'(phy_divisor), DIV_INIT);
    rd(1, v); check("R1 R3 status empty", v, 1);
    rd(0, v); check("R1 enable clear", v, 0);

    // divisor while disabled
    wr(2, 8'h34); wr(3, 8'h12);
    @(negedge clk); check("R4 divisor loaded", int'(phy_divisor), 16'h1234);
    rd(2, v); check("R4 low byte", v, 8'h34);
    rd(3, v); check("R4 high byte", v, 8'h12);

    // data while disabled, then enable
    wr(4, 8'h77);
    @(negedge clk); check("R8 dropped while off", int'(phy_valid), 0);
    wr(0, 8'hFF);
    @(negedge clk); check("R2 phy_rst low", int'(phy_rst), 0);
    check("R8 no ghost after enable", int'(phy_valid), 0);
    rd(0, v); check("R2 control readback", v, 1);

    // divisor locked
    wr(2, 8'hAA); wr(3, 8'hBB);
    @(negedge clk); check("R5 divisor locked", int'(phy_divisor), 16'h1234);

    // accept, hold, drop while full
    wr(4, 8'hA5);
    @(negedge clk); check("R6 valid", int'(phy_valid), 1);
    check("R6 payload", int'(phy_payload), 8'hA5);
    rd(1, v); check("R3 status full", v, 0);
    wr(4, 8'h5A);
    @(negedge clk); check("R7 payload kept", int'(phy_payload), 8'hA5);
    rd(4, v); check("R11 data reads zero", v, 0);
    rd(9, v); check("R11 unmapped zero", v, 0);
    check("R11 read no side effect", int'(phy_valid), 1);

    // handover
    @(posedge clk); #1; phy_ready = 1'b1;
    @(posedge clk); #1; phy_ready = 1'b0;
    @(negedge clk); check("R9 cleared after handover", int'(phy_valid), 0);

    // back-to-back stream
    @(posedge clk); #1; phy_ready = 1'b1;
    for (int i = 0; i < 12; i++) wr(4, 8'h10 + i);
    idle(3);
    @(posedge clk); #1; phy_ready = 1'b0;

    // flush on disable
    wr(4, 8'hC3);
    @(negedge clk); check("R6 held before flush", int'(phy_valid), 1);
    wr(0, 8'h00);
    @(negedge clk); check("R10 flushed", int'(phy_valid), 0);
    check("R10 phy_rst", int'(phy_rst), 1);
    wr(0, 8'h01);
    @(negedge clk); check("R10 stays empty", int'(phy_valid), 0);
    idle(2);

    check("R9 handover count", got_q.size(), exp_q.size());
    foreach (exp_q[i]) begin
      if (i < got_q.size()) check("R9 order", got_q[i], exp_q[i]);
    end
    finish_run();
  end
endmodule